// File: doc/BRIEF.md
# Gated Colour-Bar Video Pattern Generator

This block scans a 640x480 raster and produces active-low horizontal and vertical sync together with a fixed pattern of rectangular colour regions. Each of the three colours has two intensity bits. Bit 0 alone gives the dark shade, bit 1 alone gives the medium shade, and both bits together give the brightest shade. Each bit lights up when the scan position falls inside its own window rule.

The horizontal count runs at two clocks per pixel, so a 50 MHz clock produces a standard line of 1600 clocks. Outside the visible area all colour bits are held low. Each colour also has its own enable input, and a colour's enable gates both of that colour's bits.

Sync and colour outputs are registered in one shared output stage, so they stay aligned with each other. All timing counts and all windows are parameters. A window rule lights a bit when X lies in the half-open range [xlo, xhi) or when Y lies in the half-open range [ylo, yhi). X is counted in clocks and Y in lines.

Top module: `vid_bar_gen`

## Requirements
- R1: While `rst` is high at a rising edge, that edge leaves `hsync_n` and `vsync_n` at 1 and all six colour bits at 0. The scan then restarts at index 0.
- R2: After reset is released, the n-th rising edge (n = 1, 2, ...) presents the scan index n-1. The index maps to X = index mod H_TOTAL and Y = (index div H_TOTAL) mod V_TOTAL. Here H_TOTAL = H_VIS+H_FP+H_SY+H_BP and V_TOTAL = V_VIS+V_FP+V_SY+V_BP. The vertical count advances only when a line wraps.
- R3: `hsync_n` is 0 exactly when X is in [H_VIS+H_FP, H_VIS+H_FP+H_SY), and 1 otherwise.
- R4: `vsync_n` is 0 for every clock of the lines with Y in [V_VIS+V_FP, V_VIS+V_FP+V_SY), and 1 otherwise.
- R5: All six colour bits are 0 whenever X >= H_VIS or Y >= V_VIS, whatever the windows and enables say.
- R6: In the visible area with `en_red` high, `red_o[0]` follows the red dim window (default X<200 or Y>80). `red_o[1]` follows the red bright window (default 200<X<400 or 80<Y<160).
- R7: In the visible area with `en_grn` high, `grn_o[0]` and `grn_o[1]` follow the green dim and bright windows. The defaults are X>=640 or Y<40 for dim, and 700<X<900 or 300<Y<360 for bright.
- R8: In the visible area with `en_blu` high, `blu_o[0]` and `blu_o[1]` follow the blue dim and bright windows. The defaults are X>1000 or Y>400 for dim, and 1000<X<1200 or 200<Y<240 for bright.
- R9: A colour's enable, as sampled at a rising edge, gates both bits of that colour in that edge's output. Enables act independently of one another and may change on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock (two clocks per pixel) |
| rst | input | 1 | Synchronous active-high reset |
| en_red | input | 1 | Red channel enable |
| en_grn | input | 1 | Green channel enable |
| en_blu | input | 1 | Blue channel enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red_o | output | 2 | Red intensity, bit 0 dim, bit 1 bright |
| grn_o | output | 2 | Green intensity, bit 0 dim, bit 1 bright |
| blu_o | output | 2 | Blue intensity, bit 0 dim, bit 1 bright |

## Verification
Two functions can decide a colour bit in the same cycle: a window rule that reaches into the blanking interval, and the blanking override. The red dim rule "Y above a line" covers every clock of the horizontal blanking on those lines. The green and blue dim rules extend past the last visible X. The enable gate can also change on the very cycle a region begins, because the bench toggles the enables every clock during one sweep. The bench sweeps every scan position of a reduced frame under all eight static enable combinations and under that toggling pattern. It compares each output bit with a value computed from the window arithmetic, the enables and the blanking rule, so it judges both collisions on every cycle.

// File: rtl/vid_pkg.sv
package vid_pkg;

    // Scan phase of one axis
    typedef enum logic [1:0] {
        PH_VIS   = 2'd0,
        PH_FRONT = 2'd1,
        PH_SYNC  = 2'd2,
        PH_BACK  = 2'd3
    } phase_e;

    // Half-open window pair: lit when x in [xlo,xhi) or y in [ylo,yhi)
    typedef struct packed {
        logic [15:0] xlo;
        logic [15:0] xhi;
        logic [15:0] ylo;
        logic [15:0] yhi;
    } win_t;

    function automatic logic in_win(input win_t w, input logic [15:0] x, input logic [15:0] y);
        return ((x >= w.xlo) && (x < w.xhi)) || ((y >= w.ylo) && (y < w.yhi));
    endfunction

endpackage

// File: rtl/vid_scan_axis.sv
module vid_scan_axis
    import vid_pkg::*;
#(
    parameter int unsigned VIS = 1280,
    parameter int unsigned FP  = 32,
    parameter int unsigned SY  = 192,
    parameter int unsigned BP  = 96,
    localparam int unsigned TOTAL = VIS + FP + SY + BP,
    localparam int unsigned PW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [PW-1:0] pos,
    output phase_e        phase,
    output logic          wrap
);

    localparam logic [PW-1:0] LAST_VIS = PW'(VIS - 1);
    localparam logic [PW-1:0] LAST_FP  = PW'(VIS + FP - 1);
    localparam logic [PW-1:0] LAST_SY  = PW'(VIS + FP + SY - 1);
    localparam logic [PW-1:0] LAST     = PW'(TOTAL - 1);

    phase_e nxt_phase;

    // Next-phase and wrap decode
    always_comb begin
        wrap      = step && (pos == LAST);
        nxt_phase = phase;
        if (step) begin
            unique case (phase)
                PH_VIS:   if (pos == LAST_VIS) nxt_phase = PH_FRONT;
                PH_FRONT: if (pos == LAST_FP)  nxt_phase = PH_SYNC;
                PH_SYNC:  if (pos == LAST_SY)  nxt_phase = PH_BACK;
                PH_BACK:  if (pos == LAST)     nxt_phase = PH_VIS;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_VIS;
            pos   <= '0;
        end else if (step) begin
            phase <= nxt_phase;
            pos   <= wrap ? '0 : pos + 1'b1;
        end
    end

endmodule

// File: rtl/vid_colour_gate.sv
module vid_colour_gate
    import vid_pkg::*;
#(
    parameter win_t DIM_WIN    = '0,
    parameter win_t BRIGHT_WIN = '0,
    parameter int unsigned XW  = 11,
    parameter int unsigned YW  = 10
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          visible,
    input  logic          en,
    output logic [1:0]    lvl
);

    logic [15:0] xe;
    logic [15:0] ye;
    logic        gate;

    always_comb begin
        xe     = 16'(x);
        ye     = 16'(y);
        gate   = visible && en;
        lvl[0] = gate && in_win(DIM_WIN, xe, ye);
        lvl[1] = gate && in_win(BRIGHT_WIN, xe, ye);
    end

endmodule

// File: rtl/vid_bar_gen.sv
module vid_bar_gen
    import vid_pkg::*;
#(
    parameter int unsigned H_VIS = 1280,
    parameter int unsigned H_FP  = 32,
    parameter int unsigned H_SY  = 192,
    parameter int unsigned H_BP  = 96,
    parameter int unsigned V_VIS = 480,
    parameter int unsigned V_FP  = 10,
    parameter int unsigned V_SY  = 2,
    parameter int unsigned V_BP  = 33,
    parameter win_t RED_DIM = '{xlo: 16'd0,    xhi: 16'd200,   ylo: 16'd81,  yhi: 16'hFFFF},
    parameter win_t RED_BRT = '{xlo: 16'd201,  xhi: 16'd400,   ylo: 16'd81,  yhi: 16'd160},
    parameter win_t GRN_DIM = '{xlo: 16'd640,  xhi: 16'hFFFF,  ylo: 16'd0,   yhi: 16'd40},
    parameter win_t GRN_BRT = '{xlo: 16'd701,  xhi: 16'd900,   ylo: 16'd301, yhi: 16'd360},
    parameter win_t BLU_DIM = '{xlo: 16'd1001, xhi: 16'hFFFF,  ylo: 16'd401, yhi: 16'hFFFF},
    parameter win_t BLU_BRT = '{xlo: 16'd1001, xhi: 16'd1200,  ylo: 16'd201, yhi: 16'd240},
    localparam int unsigned H_TOTAL = H_VIS + H_FP + H_SY + H_BP,
    localparam int unsigned V_TOTAL = V_VIS + V_FP + V_SY + V_BP,
    localparam int unsigned HPW     = $clog2(H_TOTAL),
    localparam int unsigned VPW     = $clog2(V_TOTAL),
    localparam int unsigned NCOL    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_red,
    input  logic       en_grn,
    input  logic       en_blu,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic [1:0] red_o,
    output logic [1:0] grn_o,
    output logic [1:0] blu_o
);

    function automatic win_t dim_of(input int c);
        case (c)
            0:       return RED_DIM;
            1:       return GRN_DIM;
            default: return BLU_DIM;
        endcase
    endfunction

    function automatic win_t brt_of(input int c);
        case (c)
            0:       return RED_BRT;
            1:       return GRN_BRT;
            default: return BLU_BRT;
        endcase
    endfunction

    logic [HPW-1:0]    h_pos;
    logic [VPW-1:0]    v_pos;
    phase_e            h_phase;
    phase_e            v_phase;
    logic              h_wrap;
    logic              v_wrap;
    logic              visible;
    logic [NCOL-1:0]   en_vec;
    logic [2*NCOL-1:0] col_d;
    logic [2*NCOL-1:0] col_q;

    // Horizontal axis steps every clock (R2, R3)
    vid_scan_axis #(.VIS(H_VIS), .FP(H_FP), .SY(H_SY), .BP(H_BP)) u_h_axis (
        .clk   (clk),
        .rst   (rst),
        .step  (1'b1),
        .pos   (h_pos),
        .phase (h_phase),
        .wrap  (h_wrap)
    );

    // Vertical axis steps on line wrap (R2, R4)
    vid_scan_axis #(.VIS(V_VIS), .FP(V_FP), .SY(V_SY), .BP(V_BP)) u_v_axis (
        .clk   (clk),
        .rst   (rst),
        .step  (h_wrap),
        .pos   (v_pos),
        .phase (v_phase),
        .wrap  (v_wrap)
    );

    assign visible = (h_phase == PH_VIS) && (v_phase == PH_VIS);
    assign en_vec  = {en_blu, en_grn, en_red};

    // One region/gate slice per colour (R5..R9)
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        vid_colour_gate #(
            .DIM_WIN    (dim_of(c)),
            .BRIGHT_WIN (brt_of(c)),
            .XW         (HPW),
            .YW         (VPW)
        ) u_gate (
            .x       (h_pos),
            .y       (v_pos),
            .visible (visible),
            .en      (en_vec[c]),
            .lvl     (col_d[2*c +: 2])
        );
    end

    // Output register: sync and colour share one stage (R1)
    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            col_q   <= '0;
        end else begin
            hsync_n <= (h_phase != PH_SYNC);
            vsync_n <= (v_phase != PH_SYNC);
            col_q   <= col_d;
        end
    end

    assign red_o = col_q[1:0];
    assign grn_o = col_q[3:2];
    assign blu_o = col_q[5:4];

endmodule

// File: rtl/vid_bar_gen_chk.sv
module vid_bar_gen_chk #(
    parameter int unsigned H_TOTAL = 1600,
    parameter int unsigned HPW     = 11,
    parameter int unsigned VPW     = 10
) (
    input logic           clk,
    input logic           rst,
    input logic           en_red,
    input logic           en_grn,
    input logic           en_blu,
    input logic           hsync_n,
    input logic           vsync_n,
    input logic [1:0]     red_o,
    input logic [1:0]     grn_o,
    input logic [1:0]     blu_o,
    input logic [HPW-1:0] h_pos,
    input logic [VPW-1:0] v_pos,
    input logic           h_wrap,
    input logic           v_wrap
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (hsync_n && vsync_n && red_o == 2'b00 && grn_o == 2'b00 && blu_o == 2'b00));

    // R5
    sync_blank_chk: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n || !vsync_n) |-> (red_o == 2'b00 && grn_o == 2'b00 && blu_o == 2'b00));

    // R9
    red_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_red |=> (red_o == 2'b00));

    // R9
    grn_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_grn |=> (grn_o == 2'b00));

    // R9
    blu_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_blu |=> (blu_o == 2'b00));

    // R2
    h_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(h_pos) < H_TOTAL);

    // R2
    v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !h_wrap |=> $stable(v_pos));

    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        v_wrap |-> h_wrap);

endmodule

bind vid_bar_gen vid_bar_gen_chk #(
    .H_TOTAL (H_TOTAL),
    .HPW     (HPW),
    .VPW     (VPW)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .en_red  (en_red),
    .en_grn  (en_grn),
    .en_blu  (en_blu),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .red_o   (red_o),
    .grn_o   (grn_o),
    .blu_o   (blu_o),
    .h_pos   (h_pos),
    .v_pos   (v_pos),
    .h_wrap  (h_wrap),
    .v_wrap  (v_wrap)
);

// File: tb/vid_bar_gen_test.sv
`timescale 1ns/1ps
module vid_bar_gen_test;
    import vid_pkg::*;

    localparam int HV = 40, HF = 2, HS = 4, HB = 2;
    localparam int VV = 12, VF = 1, VS = 2, VB = 1;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int FRAME = HT * VT;

    localparam win_t W_RD = '{xlo: 16'd0,  xhi: 16'd10,   ylo: 16'd5,  yhi: 16'hFFFF};
    localparam win_t W_RB = '{xlo: 16'd11, xhi: 16'd20,   ylo: 16'd5,  yhi: 16'd8};
    localparam win_t W_GD = '{xlo: 16'd20, xhi: 16'hFFFF, ylo: 16'd0,  yhi: 16'd2};
    localparam win_t W_GB = '{xlo: 16'd25, xhi: 16'd30,   ylo: 16'd8,  yhi: 16'd10};
    localparam win_t W_BD = '{xlo: 16'd30, xhi: 16'hFFFF, ylo: 16'd10, yhi: 16'hFFFF};
    localparam win_t W_BB = '{xlo: 16'd31, xhi: 16'd36,   ylo: 16'd6,  yhi: 16'd7};

    logic clk = 1'b0;
    logic rst, en_red, en_grn, en_blu;
    logic hsync_n, vsync_n;
    logic [1:0] red_o, grn_o, blu_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vid_bar_gen #(
        .H_VIS(HV), .H_FP(HF), .H_SY(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SY(VS), .V_BP(VB),
        .RED_DIM(W_RD), .RED_BRT(W_RB),
        .GRN_DIM(W_GD), .GRN_BRT(W_GB),
        .BLU_DIM(W_BD), .BLU_BRT(W_BB)
    ) uut (
        .clk(clk), .rst(rst),
        .en_red(en_red), .en_grn(en_grn), .en_blu(en_blu),
        .hsync_n(hsync_n), .vsync_n(vsync_n),
        .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic bit hit(input win_t w, input int x, input int y);
        return (x >= int'(w.xlo) && x < int'(w.xhi)) || (y >= int'(w.ylo) && y < int'(w.yhi));
    endfunction

    function automatic logic [1:0] raw_col(input int c, input int x, input int y);
        case (c)
            0:       return {hit(W_RB, x, y), hit(W_RD, x, y)};
            1:       return {hit(W_GB, x, y), hit(W_GD, x, y)};
            default: return {hit(W_BB, x, y), hit(W_BD, x, y)};
        endcase
    endfunction

    function automatic logic [2:0] pat(input int k, input int mode);
        if (mode == 0) return 3'((k / FRAME) % 8);
        return 3'((k ^ (k >> 2)) & 7);
    endfunction

    task automatic check_idle(input string tag);
        chk(hsync_n == 1'b1, tag, int'(hsync_n), 1);
        chk(vsync_n == 1'b1, tag, int'(vsync_n), 1);
        chk({blu_o, grn_o, red_o} == 6'b0, tag, int'({blu_o, grn_o, red_o}), 0);
    endtask

    task automatic check_pos(input int idx, input logic [2:0] en);
        int x, y;
        bit vis;
        logic exp_hs, exp_vs;
        x = idx % HT;
        y = (idx / HT) % VT;
        vis = (x < HV) && (y < VV);
        exp_hs = !((x >= HV + HF) && (x < HV + HF + HS));
        exp_vs = !((y >= VV + VF) && (y < VV + VF + VS));
        chk(hsync_n == exp_hs, "R3", int'(hsync_n), int'(exp_hs));
        chk(vsync_n == exp_vs, "R4", int'(vsync_n), int'(exp_vs));
        if (x == 0 && y == 0)
            chk(hsync_n && vsync_n && red_o == (en[0] ? raw_col(0, 0, 0) : 2'b00),
                "R2", int'(red_o), int'(en[0] ? raw_col(0, 0, 0) : 2'b00));
        for (int c = 0; c < 3; c++) begin
            logic [1:0] act, exp;
            string tag;
            act = (c == 0) ? red_o : (c == 1) ? grn_o : blu_o;
            exp = (vis && en[c]) ? raw_col(c, x, y) : 2'b00;
            if (!vis)        tag = "R5";
            else if (!en[c]) tag = "R9";
            else             tag = (c == 0) ? "R6" : (c == 1) ? "R7" : "R8";
            chk(act == exp, tag, int'(act), int'(exp));
        end
    endtask

    // Inputs change at negedge; outputs sampled at negedge before changing
    task automatic sweep(input int start, input int n, input int mode);
        for (int k = 0; k < n; k++) begin
            logic [2:0] applied;
            applied = {en_blu, en_grn, en_red};
            @(posedge clk);
            @(negedge clk);
            check_pos(start + k, applied);
            {en_blu, en_grn, en_red} = pat(start + k + 1, mode);
        end
    endtask

    initial begin
        rst = 1'b1;
        {en_blu, en_grn, en_red} = 3'b111;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        {en_blu, en_grn, en_red} = pat(0, 0);
        sweep(0, 8 * FRAME, 0);
        // toggling enables, continuing the scan
        {en_blu, en_grn, en_red} = pat(8 * FRAME, 1);
        sweep(8 * FRAME, 2 * FRAME + 37, 1);
        // mid-frame reset and restart from index 0
        rst = 1'b1;
        {en_blu, en_grn, en_red} = 3'b111;
        @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        rst = 1'b0;
        {en_blu, en_grn, en_red} = pat(0, 1);
        sweep(0, FRAME + 11, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R2: watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule